// File: doc/BRIEF.md
# Single-Cycle Nibble Accumulator Processor

This block is a small processor core. Its data path is four bits wide and its program counter is eight bits wide. The program counter goes out on an address bus to an external read-only program store. The store returns one eight-bit instruction on the data bus in the same cycle. Each instruction finishes in exactly one clock.

In every instruction, the high nibble selects the operation. The low nibble is either a constant or the index of one of sixteen four-bit working registers. All arithmetic goes through a single accumulator. The ALU function is not encoded in the arithmetic instruction. A separate instruction chooses it beforehand, and the choice stays in a selector register until it is changed.

Absolute jump targets are built from two parts:
- a high nibble, taken from the instruction or from a register;
- the accumulator, used as the low nibble.

Sixteen four-bit input ports can be read into the accumulator, and sixteen registered output ports can be written from it. These ports let the core reach outside devices or act as extra storage.

Top module: `nib_core`

## Requirements
- R1: The instruction at `prog_addr` runs in one clock. Any instruction that does not jump advances `prog_addr` by one on each rising edge, and the address wraps from 0xFF to 0x00.
- R2: While `rst_n` is low at a rising edge, the following are all cleared to zero: program counter, accumulator, carry flag, zero flag, ALU selector (so the selector reads add), the sixteen working registers and every output port.
- R3: Register moves. Opcode 0x0 loads the low nibble into the accumulator. Opcode 0x1 copies working register [low nibble] into the accumulator. Opcode 0x2 copies the accumulator into working register [low nibble].
- R4: Opcode 0x3 stores the low nibble in the ALU selector. The selection stays in force for every later ALU instruction until another 0x3 is executed.
- R5: ALU instructions and flags. Opcode 0x4 applies the selected function to the accumulator (A) and the low nibble (B). Opcode 0x5 uses working register [low nibble] as B. The result goes to the accumulator. Carry and zero change only on these two opcodes, and zero is set when the four-bit result is 0.
- R6: Arithmetic selector codes:
  - 0 is A+B and 1 is A+B+carry. For both, carry is the bit-4 carry out.
  - 2 is A-B and 3 is A-B-carry. For both, carry is set on a borrow.
  - D is A+1, with carry out.
  - E is A-1, with carry on a borrow.
  - F compares. It leaves the accumulator at A, sets carry when A<B, and sets zero when A=B.
- R7: Logic and shift selector codes:
  - 4 is AND, 5 is OR, 6 is XOR, 7 is NOT A and 8 passes B. All five clear carry.
  - 9 is a left shift and A is a right shift. Each fills with 0 and puts the bit shifted out into carry.
  - B rotates left through carry and C rotates right through carry.
- R8: Opcode 0x8 jumps to {low nibble, accumulator}. Opcode 0x9 jumps to {working register [low nibble], accumulator}.
- R9: Opcode 0xA jumps to its own address plus the low nibble, sign-extended to eight bits and added modulo 256.
- R10: Opcode 0xB jumps to {low nibble, accumulator} when carry is set. Opcode 0xC does the same when zero is set. Otherwise each one advances by one.
- R11: Opcode 0xD writes the accumulator to output port [low nibble], which occupies `out_ports` bits 4n+3..4n. No other port changes. Opcode 0xE loads input port [low nibble], taken from `in_ports` bits 4n+3..4n, into the accumulator.
- R12: Opcodes 0x6, 0x7 and 0xF only advance the program counter. They leave the accumulator, the flags, the registers and the ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_addr | output | 8 | Program counter, used as the fetch address |
| prog_data | input | 8 | Instruction returned by the program store in the same cycle |
| in_ports | input | 64 | Sixteen four-bit input ports; port n is bits 4n+3..4n |
| out_ports | output | 64 | Sixteen registered four-bit output ports; port n is bits 4n+3..4n |

## Verification
The bench builds the core with its default data width of four. With that width the program space is the full 256 bytes and there are sixteen registers and sixteen ports, so the tests can reach the address wrap, jumps into the upper half of the program space and writes to the top port.

Every ALU selector code runs from a small generated program. That program first forces the incoming carry, then reports the carry and zero flags by taking conditional jumps to one of four distinct halt addresses. Two further programs check, through the ports, that the selector survives other instructions and that no-operation opcodes keep the flags.

// File: rtl/nib_pkg.sv
// Shared encodings for the nibble accumulator core.
// Assumes a four-bit operation field in the top nibble of each instruction.
package nib_pkg;

    // Operation field of an instruction
    typedef enum logic [3:0] {
        OP_LDI  = 4'h0,
        OP_LDA  = 4'h1,
        OP_STA  = 4'h2,
        OP_SEL  = 4'h3,
        OP_ALI  = 4'h4,
        OP_ALR  = 4'h5,
        OP_NOP6 = 4'h6,
        OP_NOP7 = 4'h7,
        OP_JAI  = 4'h8,
        OP_JAR  = 4'h9,
        OP_JRL  = 4'hA,
        OP_JC   = 4'hB,
        OP_JZ   = 4'hC,
        OP_OUT  = 4'hD,
        OP_IN   = 4'hE,
        OP_NOPF = 4'hF
    } opcode_e;

    // Function held in the ALU selector register
    typedef enum logic [3:0] {
        ALU_ADD  = 4'h0,
        ALU_ADC  = 4'h1,
        ALU_SUB  = 4'h2,
        ALU_SBB  = 4'h3,
        ALU_AND  = 4'h4,
        ALU_OR   = 4'h5,
        ALU_XOR  = 4'h6,
        ALU_NOTA = 4'h7,
        ALU_PASB = 4'h8,
        ALU_SHL  = 4'h9,
        ALU_SHR  = 4'hA,
        ALU_RLC  = 4'hB,
        ALU_RRC  = 4'hC,
        ALU_INC  = 4'hD,
        ALU_DEC  = 4'hE,
        ALU_CMP  = 4'hF
    } alu_op_e;

    // Source of the next accumulator value
    typedef enum logic [2:0] {
        ACC_KEEP = 3'd0,
        ACC_IMM  = 3'd1,
        ACC_REG  = 3'd2,
        ACC_ALU  = 3'd3,
        ACC_PORT = 3'd4
    } acc_src_e;

    // Source of the next program counter
    typedef enum logic [1:0] {
        PC_STEP = 2'd0,
        PC_ABS  = 2'd1,
        PC_REL  = 2'd2
    } pc_sel_e;

    // Control bundle produced by the decoder
    typedef struct packed {
        acc_src_e acc_src;
        logic     reg_we;
        logic     sel_we;
        logic     flag_we;
        logic     out_we;
        logic     b_from_reg;
        logic     hi_from_reg;
        pc_sel_e  pc_sel;
    } ctrl_t;

endpackage

// File: rtl/nib_decode.sv
// Instruction decoder: turns the operation field and current flags into
// the control bundle for one cycle. Purely combinational; conditional jumps
// are resolved here, so the top only sees step, absolute or relative.
module nib_decode
    import nib_pkg::*;
(
    input  opcode_e op,
    input  logic    carry,
    input  logic    zero,
    output ctrl_t   ctrl
);

    // Map each operation to its control settings
    always_comb begin
        ctrl = '0;
        case (op)
            OP_LDI:  ctrl.acc_src = ACC_IMM;
            OP_LDA:  ctrl.acc_src = ACC_REG;
            OP_STA:  ctrl.reg_we  = 1'b1;
            OP_SEL:  ctrl.sel_we  = 1'b1;
            OP_ALI: begin
                ctrl.acc_src = ACC_ALU;
                ctrl.flag_we = 1'b1;
            end
            OP_ALR: begin
                ctrl.acc_src    = ACC_ALU;
                ctrl.flag_we    = 1'b1;
                ctrl.b_from_reg = 1'b1;
            end
            OP_NOP6, OP_NOP7, OP_NOPF: ctrl.pc_sel = PC_STEP;
            OP_JAI:  ctrl.pc_sel = PC_ABS;
            OP_JAR: begin
                ctrl.pc_sel      = PC_ABS;
                ctrl.hi_from_reg = 1'b1;
            end
            OP_JRL:  ctrl.pc_sel = PC_REL;
            OP_JC:   ctrl.pc_sel = carry ? PC_ABS : PC_STEP;
            OP_JZ:   ctrl.pc_sel = zero ? PC_ABS : PC_STEP;
            OP_OUT:  ctrl.out_we  = 1'b1;
            OP_IN:   ctrl.acc_src = ACC_PORT;
        endcase
    end

endmodule

// File: rtl/nib_alu.sv
// Sixteen-function ALU of DW bits. Produces a result, a carry/borrow and a
// zero indication. Compare returns A unchanged and flags on A-B.
// Assumes DW >= 2.
module nib_alu
    import nib_pkg::*;
#(
    parameter int DW = 4
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] y,
    output logic          cout,
    output logic          zf
);

    logic [DW:0]   wide;
    logic [DW-1:0] zsrc;

    // Compute result and carry for the selected function
    always_comb begin
        wide = '0;
        y    = a;
        cout = 1'b0;
        zsrc = '0;
        case (op)
            ALU_ADD: begin
                wide = {1'b0, a} + {1'b0, b};
                y = wide[DW-1:0]; cout = wide[DW];
            end
            ALU_ADC: begin
                wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
                y = wide[DW-1:0]; cout = wide[DW];
            end
            ALU_SUB: begin
                wide = {1'b0, a} - {1'b0, b};
                y = wide[DW-1:0]; cout = wide[DW];
            end
            ALU_SBB: begin
                wide = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
                y = wide[DW-1:0]; cout = wide[DW];
            end
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_NOTA: y = ~a;
            ALU_PASB: y = b;
            ALU_SHL: begin
                y = {a[DW-2:0], 1'b0}; cout = a[DW-1];
            end
            ALU_SHR: begin
                y = {1'b0, a[DW-1:1]}; cout = a[0];
            end
            ALU_RLC: begin
                y = {a[DW-2:0], cin}; cout = a[DW-1];
            end
            ALU_RRC: begin
                y = {cin, a[DW-1:1]}; cout = a[0];
            end
            ALU_INC: begin
                wide = {1'b0, a} + (DW+1)'(1);
                y = wide[DW-1:0]; cout = wide[DW];
            end
            ALU_DEC: begin
                wide = {1'b0, a} - (DW+1)'(1);
                y = wide[DW-1:0]; cout = wide[DW];
            end
            ALU_CMP: begin
                wide = {1'b0, a} - {1'b0, b};
                y = a; cout = wide[DW];
            end
        endcase
        zsrc = (op == ALU_CMP) ? wide[DW-1:0] : y;
    end

    // Zero flag follows the result, or the difference for compare
    always_comb zf = (zsrc == '0);

endmodule

// File: rtl/nib_regfile.sv
// Bank of DEPTH working registers, DW bits each, one write and one
// asynchronous read port. Cleared by synchronous active-low reset.
module nib_regfile #(
    parameter int DW    = 4,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DW-1:0]            rd_data
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH*DW-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DW-1:0] cell_q;

        // Hold one register; load when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= '0;
            else if (we && wr_idx == IDX_W'(g))
                cell_q <= wr_data;
        end

        assign flat[g*DW +: DW] = cell_q;
    end

    // Read the addressed register
    always_comb rd_data = flat[rd_idx*DW +: DW];

endmodule

// File: rtl/nib_portbank.sv
// Registered output ports and input port selection. Each output port holds
// its value until addressed by a write; the input side is a plain mux.
module nib_portbank #(
    parameter int DW    = 4,
    parameter int COUNT = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(COUNT)-1:0] idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [COUNT*DW-1:0]      in_flat,
    output logic [DW-1:0]            in_data,
    output logic [COUNT*DW-1:0]      out_flat
);

    localparam int IDX_W = $clog2(COUNT);

    for (genvar g = 0; g < COUNT; g++) begin : g_port
        logic [DW-1:0] port_q;

        // Latch the accumulator into this port when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                port_q <= '0;
            else if (we && idx == IDX_W'(g))
                port_q <= wr_data;
        end

        assign out_flat[g*DW +: DW] = port_q;
    end

    // Select the addressed input port
    always_comb in_data = in_flat[idx*DW +: DW];

    // Ports hold whenever no write is requested
    assert_port_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !we) |=> $stable(out_flat));

endmodule

// File: rtl/nib_core.sv
// Single-cycle accumulator processor with a DATA_W-bit data path and a
// 2*DATA_W-bit program counter. The program store must answer prog_addr
// combinationally within the same cycle; all state updates on the rising
// edge. Assumes DATA_W = 4 for the operation field width.
module nib_core
    import nib_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    output logic [2*DATA_W-1:0]          prog_addr,
    input  logic [2*DATA_W-1:0]          prog_data,
    input  logic [(2**DATA_W)*DATA_W-1:0] in_ports,
    output logic [(2**DATA_W)*DATA_W-1:0] out_ports
);

    localparam int ADDR_W = 2 * DATA_W;
    localparam int SLOTS  = 2 ** DATA_W;

    logic [ADDR_W-1:0] pc_q, pc_d;
    logic [DATA_W-1:0] acc_q, acc_d;
    logic              carry_q, zero_q;
    alu_op_e           alu_sel_q;

    opcode_e           op;
    logic [DATA_W-1:0] imm;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] reg_rd, port_rd, alu_b, alu_y, hi_nib;
    logic              alu_c, alu_z;

    // Split the fetched instruction
    always_comb begin
        op  = opcode_e'(prog_data[ADDR_W-1 -: DATA_W]);
        imm = prog_data[DATA_W-1:0];
    end

    nib_decode u_decode (
        .op    (op),
        .carry (carry_q),
        .zero  (zero_q),
        .ctrl  (ctrl)
    );

    nib_regfile #(.DW(DATA_W), .DEPTH(SLOTS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctrl.reg_we),
        .wr_idx  (imm),
        .wr_data (acc_q),
        .rd_idx  (imm),
        .rd_data (reg_rd)
    );

    nib_portbank #(.DW(DATA_W), .COUNT(SLOTS)) u_ports (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl.out_we),
        .idx      (imm),
        .wr_data  (acc_q),
        .in_flat  (in_ports),
        .in_data  (port_rd),
        .out_flat (out_ports)
    );

    // Second ALU operand and jump high nibble
    always_comb begin
        alu_b  = ctrl.b_from_reg  ? reg_rd : imm;
        hi_nib = ctrl.hi_from_reg ? reg_rd : imm;
    end

    nib_alu #(.DW(DATA_W)) u_alu (
        .op   (alu_sel_q),
        .a    (acc_q),
        .b    (alu_b),
        .cin  (carry_q),
        .y    (alu_y),
        .cout (alu_c),
        .zf   (alu_z)
    );

    // Choose the next accumulator value
    always_comb begin
        case (ctrl.acc_src)
            ACC_IMM:  acc_d = imm;
            ACC_REG:  acc_d = reg_rd;
            ACC_ALU:  acc_d = alu_y;
            ACC_PORT: acc_d = port_rd;
            default:  acc_d = acc_q;
        endcase
    end

    // Choose the next program counter
    always_comb begin
        case (ctrl.pc_sel)
            PC_ABS:  pc_d = {hi_nib, acc_q};
            PC_REL:  pc_d = pc_q + {{DATA_W{imm[DATA_W-1]}}, imm};
            default: pc_d = pc_q + ADDR_W'(1);
        endcase
    end

    // Commit program counter, accumulator, flags and selector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= '0;
            acc_q     <= '0;
            carry_q   <= 1'b0;
            zero_q    <= 1'b0;
            alu_sel_q <= ALU_ADD;
        end else begin
            pc_q  <= pc_d;
            acc_q <= acc_d;
            if (ctrl.flag_we) begin
                carry_q <= alu_c;
                zero_q  <= alu_z;
            end
            if (ctrl.sel_we)
                alu_sel_q <= alu_op_e'(imm);
        end
    end

    assign prog_addr = pc_q;

    // Flags change only on ALU instructions
    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op != OP_ALI && op != OP_ALR) |=> $stable({carry_q, zero_q}));

    // Selector changes only on the select instruction
    assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op != OP_SEL) |=> $stable(alu_sel_q));

    // Register load brings the register value into the accumulator
    assert_reg_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op == OP_LDA) |=> acc_q == $past(reg_rd));

    // Immediate absolute jump target
    assert_abs_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op == OP_JAI) |=> prog_addr == {$past(imm), $past(acc_q)});

    // Relative jump adds the sign-extended offset to its own address
    assert_rel_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op == OP_JRL) |=> prog_addr == $past(pc_q) + {{DATA_W{$past(imm[DATA_W-1])}}, $past(imm)});

    // Carry jump falls through when carry is clear
    assert_jc_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op == OP_JC && !carry_q) |=> prog_addr == $past(pc_q) + ADDR_W'(1));

    // No-operation opcodes only step the counter
    assert_nop_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (op == OP_NOP6 || op == OP_NOP7 || op == OP_NOPF))
        |=> (prog_addr == $past(pc_q) + ADDR_W'(1)) && $stable(acc_q));

endmodule

// File: tb/nib_core_bench.sv
`timescale 1ns/1ps
module nib_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  prog_addr;
    logic [7:0]  prog_data;
    logic [63:0] in_ports = '0;
    logic [63:0] out_ports;
    logic [7:0]  mem [256];

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign prog_data = mem[prog_addr];

    nib_core u_nib_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .in_ports  (in_ports),
        .out_ports (out_ports)
    );

    // Vector: op a b cin | result carry zero, one hex digit each
    localparam int NV = 23;
    localparam logic [27:0] ALU_VEC [NV] = '{
        28'h0980110, 28'h0880011, 28'h1781011, 28'h1341800,
        28'h2350E10, 28'h2551001, 28'h3541001, 28'h3001F10,
        28'h3720500, 28'h4CA1800, 28'h5000001, 28'h6661001,
        28'h7530A00, 28'h8701001, 28'h9900210, 28'hA100011,
        28'hB801110, 28'hC100011, 28'hC601B00, 28'hDF00011,
        28'hE000F10, 28'hF330301, 28'hF270210
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold_and_fill(input logic [7:0] fillv);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = fillv;
    endtask

    task automatic release_run(input int cycles);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Table walk: every ALU selector code (R5, R6, R7, R10)
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            logic [3:0]  vop, va, vb, vc, vr, vcar, vz;
            logic [7:0]  halt;
            v = ALU_VEC[i];
            {vop, va, vb, vc, vr, vcar, vz} = v;
            hold_and_fill(8'hA0);
            mem[0]  = 8'h0F;
            mem[1]  = 8'h30;
            mem[2]  = {4'h4, vc};
            mem[3]  = {4'h3, vop};
            mem[4]  = {4'h0, va};
            mem[5]  = {4'h4, vb};
            mem[6]  = 8'hD0;
            mem[7]  = 8'h00;
            mem[8]  = 8'hB8;
            mem[9]  = 8'hC9;
            mem[10] = 8'h8A;
            mem[8'h80] = 8'h00;
            mem[8'h81] = 8'hCB;
            mem[8'h82] = 8'h8C;
            release_run(30);
            halt = vcar[0] ? (vz[0] ? 8'hB0 : 8'hC0) : (vz[0] ? 8'h90 : 8'hA0);
            if (vop <= 4'h3 || vop >= 4'hD)
                check($sformatf("R6 result sel=%h", vop), {60'd0, out_ports[3:0]}, {60'd0, vr});
            else
                check($sformatf("R7 result sel=%h", vop), {60'd0, out_ports[3:0]}, {60'd0, vr});
            check($sformatf("R5 R10 flags via halt sel=%h", vop), {56'd0, prog_addr}, {56'd0, halt});
        end

        // Reset state while held (R2)
        hold_and_fill(8'hF0);
        repeat (2) @(negedge clk);
        check("R2 out ports cleared", out_ports, 64'd0);
        check("R2 counter cleared", {56'd0, prog_addr}, 64'd0);

        // Counter steps and wraps; NOPs touch nothing (R1, R12)
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 counter step", {56'd0, prog_addr}, 64'd5);
        repeat (254) @(negedge clk);
        check("R1 counter wrap", {56'd0, prog_addr}, 64'd3);
        check("R12 nop leaves ports", out_ports, 64'd0);

        // Selector starts at add and persists (R2, R4)
        hold_and_fill(8'hA0);
        mem[0] = 8'h09; mem[1] = 8'h48; mem[2] = 8'hD0;
        mem[3] = 8'h36; mem[4] = 8'h05; mem[5] = 8'h43; mem[6] = 8'hD1;
        mem[7] = 8'h0C; mem[8] = 8'h4A; mem[9] = 8'hD2;
        release_run(16);
        check("R2 selector resets to add", {60'd0, out_ports[3:0]}, 64'h1);
        check("R4 selector applied", {60'd0, out_ports[7:4]}, 64'h6);
        check("R4 selector persists", {60'd0, out_ports[11:8]}, 64'h6);

        // Registers, register operand, register jump (R3, R5, R8)
        hold_and_fill(8'hA0);
        mem[0] = 8'h05; mem[1] = 8'h23; mem[2] = 8'h00; mem[3] = 8'h13;
        mem[4] = 8'hD2; mem[5] = 8'h30; mem[6] = 8'h01; mem[7] = 8'h53;
        mem[8] = 8'hD4; mem[9] = 8'h07; mem[10] = 8'h29; mem[11] = 8'h04;
        mem[12] = 8'h99;
        release_run(20);
        check("R3 store then load", {60'd0, out_ports[11:8]}, 64'h5);
        check("R5 register operand", {60'd0, out_ports[19:16]}, 64'h6);
        check("R8 register jump", {56'd0, prog_addr}, 64'h74);

        // Input read and output write isolation (R11)
        hold_and_fill(8'hA0);
        in_ports = 64'h0123456789ABCDEF;
        mem[0] = 8'hE6; mem[1] = 8'hDF; mem[2] = 8'hE0; mem[3] = 8'hD7;
        release_run(10);
        check("R11 port read and write", out_ports, 64'h90000000F0000000);

        // Backward and forward relative jumps (R9)
        hold_and_fill(8'hA0);
        mem[0] = 8'h81;
        mem[8'h10] = 8'hAE; mem[8'h0E] = 8'hA3;
        mem[8'h11] = 8'h07; mem[8'h12] = 8'hD3;
        release_run(15);
        check("R9 relative halt", {56'd0, prog_addr}, 64'h13);
        check("R9 relative path", out_ports, 64'h7000);

        // NOPs preserve carry and accumulator (R12)
        hold_and_fill(8'hA0);
        mem[0] = 8'h0F; mem[1] = 8'h41; mem[2] = 8'h03; mem[3] = 8'h65;
        mem[4] = 8'h7A; mem[5] = 8'hF1; mem[6] = 8'hD0; mem[7] = 8'h00;
        mem[8] = 8'hB5;
        release_run(16);
        check("R12 acc after nops", out_ports, 64'h3);
        check("R12 carry after nops", {56'd0, prog_addr}, 64'h50);

        // Reset in mid-run clears ports (R2)
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 mid-run port clear", out_ports, 64'd0);
        check("R2 mid-run counter clear", {56'd0, prog_addr}, 64'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule